// File: doc/BRIEF.md
# N-of-M Sparse Distributed Associative Memory

This block stores associations between sparse binary address codes and sparse binary data codes, and recalls a data code when it is given an address. An address code and a data code are N-of-M words: exactly N of their M bits are set. No location is indexed. Recall works on content alone.

Recall happens in two stages. In the first stage, each of `HID` hidden units holds a fixed binary weight row. The row is produced by a seeded LFSR after every reset. For each unit, the block counts the overlap between the address and that unit's row, and it activates the `K` units with the largest overlap. In the second stage, a binary correlation matrix links the hidden units to the data bits. A write ORs the outer product of the active-unit mask and the data code into this matrix. A read adds up, for each data bit, the matrix entries in the active rows, and returns the `D` bits with the highest sums.

The write port and the read-request port are both valid/ready. A request is taken on a cycle where valid and ready are both high. While the block is busy, both ready outputs stay low, so the requester must hold valid and its payload until it is accepted. Read results come back as a one-cycle `rd_done` strobe with `rd_data`. This result path is plain and has no back-pressure.

Top module: `sdm_assoc_mem`

## Requirements
- R1: While reset is asserted, `wr_ready`, `rd_ready` and `rd_done` are low and `rd_data` is zero. After reset is released, both ready outputs stay low for the first `HID+1` rising edges, which is the time taken to rebuild the decoder rows. Both ready outputs are high after edge `HID+1` when no request is pending.
- R2: Decoder row `h` is the low `ADDR_W` bits of a 32-bit Galois LFSR after `h+1` steps from `SEED`. Each step is `s' = (s >> 1) ^ (s[0] ? 32'hA3000000 : 0)`. After a later reset the same rows are rebuilt, so identical write/read histories give identical results.
- R3: Every request activates exactly `K` hidden units. These are the units whose rows have the largest popcount of `addr & row`. When overlaps are equal, the lower unit index wins.
- R4: A write sets matrix bit `[h][j]` for every active unit `h` and every set data bit `j`, and never clears a bit. Because weights saturate at 1, writing the same pair again leaves every later read unchanged.
- R5: A read returns exactly `D` set bits. These are the data bits with the highest count of set matrix entries over the active units. When counts are equal, the lower bit index wins.
- R6: `rd_done` goes high for exactly one cycle, `K+D+2` rising edges after the edge that accepts the read. `rd_data` changes only in a cycle where `rd_done` is high, and it holds its value otherwise.
- R7: `wr_ready` is high only when the block is idle. `rd_ready` is high only when the block is idle and `wr_valid` is low. A write and a read that are offered together are therefore serialized with the write first, and the read observes that write.
- R8: A read from a memory that holds no writes returns bits `0` to `D-1` set, because all sums tie.
- R9: A read does not alter the matrix: two consecutive reads of the same address return the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with wr_valid |
| wr_addr | input | ADDR_W | Address code of the pair to store |
| wr_data | input | DATA_W | Data code of the pair to store |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_addr | input | ADDR_W | Address code to recall from |
| rd_done | output | 1 | One-cycle strobe marking a read result |
| rd_data | output | DATA_W | Recalled data code, held between strobes |

## Verification
The assertions assume that at most one read is in flight, which the handshake guarantees. They also assume that a requester keeps valid asserted until ready accepts it, so the latency counter starts on a true acceptance edge. The recall logic does not need its inputs to be N-of-M codes. The stimulus still draws every address and data word with exactly N set bits from a fixed-seed random source, and it always holds valid and payload steady until acceptance. The only overlap the stimulus produces on purpose is a write and a read offered in the same cycle.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'hA300_0000;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_DEC,
    ST_SUM
  } sdm_state_t;

  typedef enum logic {
    OP_WRITE,
    OP_READ
  } sdm_op_t;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

endpackage

// File: rtl/sdm_row_gen.sv
module sdm_row_gen
  import sdm_pkg::*;
#(
  parameter int HID = 64,
  parameter int ADDR_W = 32,
  parameter logic [LFSR_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    row_we,
  output logic [$clog2(HID)-1:0]  row_idx,
  output logic [ADDR_W-1:0]       row_val,
  output logic                    init_done
);
  localparam int IDX_W = $clog2(HID);

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_n;
  logic [IDX_W-1:0]  idx_q;
  logic              running_q;

  assign lfsr_n  = lfsr_next(lfsr_q);
  assign row_we  = running_q;
  assign row_idx = idx_q;
  assign row_val = lfsr_n[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q    <= SEED;
      idx_q     <= '0;
      running_q <= 1'b1;
      init_done <= 1'b0;
    end else if (running_q) begin
      lfsr_q <= lfsr_n;
      idx_q  <= idx_q + 1'b1;
      if (idx_q == IDX_W'(HID - 1)) begin
        running_q <= 1'b0;
        init_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdm_addr_decoder.sv
module sdm_addr_decoder #(
  parameter int HID = 64,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(HID),
  localparam int OV_W = $clog2(ADDR_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 row_we,
  input  logic [IDX_W-1:0]     row_idx,
  input  logic [ADDR_W-1:0]    row_val,
  input  logic [ADDR_W-1:0]    addr,
  output logic [HID*OV_W-1:0]  scores
);
  logic [ADDR_W-1:0] rows_q [HID];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int h = 0; h < HID; h++) rows_q[h] <= '0;
    end else if (row_we) begin
      rows_q[row_idx] <= row_val;
    end
  end

  for (genvar h = 0; h < HID; h++) begin : g_unit
    assign scores[h*OV_W +: OV_W] = OV_W'($countones(addr & rows_q[h]));
  end

endmodule

// File: rtl/sdm_topk.sv
module sdm_topk #(
  parameter int N_IN = 64,
  parameter int SW = 6,
  parameter int K = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_IN*SW-1:0] scores,
  output logic [N_IN-1:0]    sel,
  output logic               done
);
  localparam int IW = $clog2(N_IN);
  localparam int CW = $clog2(K + 1);

  logic          busy_q;
  logic [CW-1:0] picks_q;
  logic [IW-1:0] best_idx;
  logic [SW-1:0] best_val;
  logic          found;

  // lowest index wins on equal score: only a strictly larger score replaces
  always_comb begin
    best_idx = '0;
    best_val = '0;
    found    = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (!sel[i] && (!found || scores[i*SW +: SW] > best_val)) begin
        found    = 1'b1;
        best_val = scores[i*SW +: SW];
        best_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      picks_q <= '0;
      sel     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        picks_q <= '0;
        sel     <= '0;
      end else if (busy_q) begin
        sel[best_idx] <= 1'b1;
        picks_q       <= picks_q + 1'b1;
        if (picks_q == CW'(K - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sdm_corr_matrix.sv
module sdm_corr_matrix #(
  parameter int HID = 64,
  parameter int DATA_W = 32,
  localparam int SUM_W = $clog2(HID + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [HID-1:0]          hid_mask,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [DATA_W*SUM_W-1:0] sums
);
  logic [DATA_W-1:0] w_q [HID];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int h = 0; h < HID; h++) w_q[h] <= '0;
    end else if (wr_en) begin
      for (int h = 0; h < HID; h++) begin
        if (hid_mask[h]) w_q[h] <= w_q[h] | wr_data;
      end
    end
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_col
    logic [HID-1:0] col;
    always_comb begin
      for (int h = 0; h < HID; h++) col[h] = w_q[h][j];
    end
    assign sums[j*SUM_W +: SUM_W] = SUM_W'($countones(col & hid_mask));
  end

endmodule

// File: rtl/sdm_assoc_mem.sv
module sdm_assoc_mem
  import sdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int HID = 64,
  parameter int K = 4,
  parameter int D = 4,
  parameter logic [LFSR_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(HID);
  localparam int OV_W  = $clog2(ADDR_W + 1);
  localparam int SUM_W = $clog2(HID + 1);

  sdm_state_t        state_q;
  sdm_op_t           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic              row_we;
  logic [IDX_W-1:0]  row_idx;
  logic [ADDR_W-1:0] row_val;
  logic              init_done;

  logic [HID*OV_W-1:0]     hid_scores;
  logic [HID-1:0]          hid_sel;
  logic                    dec_done;
  logic [DATA_W*SUM_W-1:0] bit_sums;
  logic [DATA_W-1:0]       bit_sel;
  logic                    dat_done;

  logic wr_go, rd_go, dec_start, dat_start, mat_we;

  assign wr_ready  = (state_q == ST_IDLE);
  assign rd_ready  = (state_q == ST_IDLE) && !wr_valid;
  assign wr_go     = wr_valid && wr_ready;
  assign rd_go     = rd_valid && rd_ready;
  assign dec_start = wr_go || rd_go;
  assign dat_start = (state_q == ST_DEC) && dec_done && (op_q == OP_READ);
  assign mat_we    = (state_q == ST_DEC) && dec_done && (op_q == OP_WRITE);

  sdm_row_gen #(.HID(HID), .ADDR_W(ADDR_W), .SEED(SEED)) u_rows (
    .clk(clk), .rst_n(rst_n), .row_we(row_we), .row_idx(row_idx),
    .row_val(row_val), .init_done(init_done)
  );

  sdm_addr_decoder #(.HID(HID), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .row_we(row_we), .row_idx(row_idx),
    .row_val(row_val), .addr(addr_q), .scores(hid_scores)
  );

  sdm_topk #(.N_IN(HID), .SW(OV_W), .K(K)) u_hid_sel (
    .clk(clk), .rst_n(rst_n), .start(dec_start), .scores(hid_scores),
    .sel(hid_sel), .done(dec_done)
  );

  sdm_corr_matrix #(.HID(HID), .DATA_W(DATA_W)) u_mat (
    .clk(clk), .rst_n(rst_n), .wr_en(mat_we), .hid_mask(hid_sel),
    .wr_data(data_q), .sums(bit_sums)
  );

  sdm_topk #(.N_IN(DATA_W), .SW(SUM_W), .K(D)) u_bit_sel (
    .clk(clk), .rst_n(rst_n), .start(dat_start), .scores(bit_sums),
    .sel(bit_sel), .done(dat_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      op_q    <= OP_WRITE;
      addr_q  <= '0;
      data_q  <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      case (state_q)
        ST_INIT: if (init_done) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (wr_go) begin
            op_q    <= OP_WRITE;
            addr_q  <= wr_addr;
            data_q  <= wr_data;
            state_q <= ST_DEC;
          end else if (rd_go) begin
            op_q    <= OP_READ;
            addr_q  <= rd_addr;
            state_q <= ST_DEC;
          end
        end
        ST_DEC: if (dec_done) state_q <= (op_q == OP_READ) ? ST_SUM : ST_IDLE;
        ST_SUM: begin
          if (dat_done) begin
            rd_done <= 1'b1;
            rd_data <= bit_sel;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdm_assoc_mem_chk.sv
module sdm_assoc_mem_chk #(
  parameter int HID = 64,
  parameter int K = 4,
  parameter int D = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_done,
  input logic [DATA_W-1:0] rd_data
);
  localparam int LAT = K + D + 2;
  localparam int CW  = $clog2(HID + 2);

  logic [CW-1:0] init_cnt;
  logic          rd_busy;
  logic [7:0]    lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_cnt <= '0;
      rd_busy  <= 1'b0;
      lat_cnt  <= '0;
    end else begin
      if (init_cnt < CW'(HID)) init_cnt <= init_cnt + 1'b1;
      if (rd_valid && rd_ready) begin
        rd_busy <= 1'b1;
        lat_cnt <= '0;
      end else if (rd_done) begin
        rd_busy <= 1'b0;
      end else if (rd_busy && lat_cnt != 8'hFF) begin
        lat_cnt <= lat_cnt + 1'b1;
      end
    end
  end

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (init_cnt < CW'(HID)) |-> (!wr_ready && !rd_ready));

  p_ready_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (wr_ready && !wr_valid));

  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_done) |-> (!wr_ready && !rd_ready));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (rd_busy && lat_cnt == 8'(LAT)));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(rd_data));

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ($countones(rd_data) == D));

endmodule

bind sdm_assoc_mem sdm_assoc_mem_chk #(
  .HID(HID), .K(K), .D(D), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_done(rd_done), .rd_data(rd_data)
);

// File: tb/sim_sdm_assoc_mem.sv
`timescale 1ns/1ps
module sim_sdm_assoc_mem;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int HID = 64;
  localparam int K = 4;
  localparam int D = 4;
  localparam int NSET = 4;
  localparam logic [31:0] SEED = 32'h1D87_2B41;
  localparam int LAT = K + D + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic wr_ready, rd_ready, rd_done;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] rows_m [HID];
  logic [DATA_W-1:0] wm [HID];
  logic [ADDR_W-1:0] st_a [64];
  logic [DATA_W-1:0] st_d [64];
  int n_st = 0;

  always #10 clk = ~clk;

  sdm_assoc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HID(HID), .K(K), .D(D),
                  .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // R2 row model
  function automatic void build_rows();
    logic [31:0] s = SEED;
    for (int h = 0; h < HID; h++) begin
      s = (s >> 1) ^ (s[0] ? 32'hA300_0000 : 32'h0);
      rows_m[h] = s[ADDR_W-1:0];
    end
  endfunction

  function automatic logic [ADDR_W-1:0] rand_code(input int w);
    logic [ADDR_W-1:0] v = '0;
    while ($countones(v) < NSET) v[$urandom % w] = 1'b1;
    return v;
  endfunction

  // R3 decoder model
  function automatic logic [HID-1:0] m_decode(input logic [ADDR_W-1:0] a);
    logic [HID-1:0] m = '0;
    int ov [HID];
    for (int h = 0; h < HID; h++) ov[h] = $countones(a & rows_m[h]);
    for (int p = 0; p < K; p++) begin
      int bi = 0;
      int bv = -1;
      for (int h = 0; h < HID; h++)
        if (!m[h] && ov[h] > bv) begin bv = ov[h]; bi = h; end
      m[bi] = 1'b1;
    end
    return m;
  endfunction

  // R5 recall model
  function automatic logic [DATA_W-1:0] m_read(input logic [ADDR_W-1:0] a);
    logic [HID-1:0] act = m_decode(a);
    logic [DATA_W-1:0] r = '0;
    int sm [DATA_W];
    for (int j = 0; j < DATA_W; j++) begin
      sm[j] = 0;
      for (int h = 0; h < HID; h++) if (act[h] && wm[h][j]) sm[j]++;
    end
    for (int p = 0; p < D; p++) begin
      int bi = 0;
      int bv = -1;
      for (int j = 0; j < DATA_W; j++)
        if (!r[j] && sm[j] > bv) begin bv = sm[j]; bi = j; end
      r[bi] = 1'b1;
    end
    return r;
  endfunction

  function automatic void m_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [HID-1:0] act = m_decode(a);
    for (int h = 0; h < HID; h++) if (act[h]) wm[h] = wm[h] | d;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_ready && !rd_ready && !rd_done && rd_data == '0, "R1 reset outputs",
        {rd_data, 29'b0, wr_ready, rd_ready, rd_done}, 64'h0);
    for (int h = 0; h < HID; h++) wm[h] = '0;
    rst_n = 1'b1;
    repeat (HID) @(negedge clk);
    chk(!wr_ready && !rd_ready, "R1 still building rows", {wr_ready, rd_ready}, 0);
    @(negedge clk);
    chk(wr_ready && rd_ready, "R1 ready after build", {wr_ready, rd_ready}, 3);
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_write(a, d);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] q);
    int lat;
    rd_addr = a; rd_valid = 1'b1;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    lat = 0;
    while (!rd_done && lat < 200) begin @(negedge clk); lat++; end
    q = rd_data;
    chk(lat == LAT, "R6 latency", 64'(lat), 64'(LAT));
    chk($countones(q) == D, "R5 popcount", 64'($countones(q)), 64'(D));
    @(negedge clk);
    chk(!rd_done && rd_data == q, "R6 pulse and hold", {rd_data, 31'b0, rd_done},
        {q, 32'b0});
  endtask

  task automatic read_cmp(input logic [ADDR_W-1:0] a, input string tag);
    logic [DATA_W-1:0] q, e;
    e = m_read(a);
    do_read(a, q);
    chk(q == e, tag, 64'(q), 64'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [DATA_W-1:0] q1, q2;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    void'($urandom(32'd20251));
    build_rows();
    do_reset();

    // R8 empty memory recall
    do_read(rand_code(ADDR_W), q1);
    chk(q1 == DATA_W'((1 << D) - 1), "R8 empty read", 64'(q1), 64'((1 << D) - 1));

    // random mixed traffic: R3 R4 R5
    for (int it = 0; it < 90; it++) begin
      if (n_st < 64 && ($urandom % 2 == 0 || n_st == 0)) begin
        a = rand_code(ADDR_W); d = rand_code(DATA_W);
        st_a[n_st] = a; st_d[n_st] = d; n_st++;
        do_write(a, d);
      end else begin
        read_cmp(st_a[$urandom % n_st], "R3 R5 recall");
      end
    end

    // R4 repeated write changes nothing
    do_read(st_a[0], q1);
    do_write(st_a[0], st_d[0]);
    do_read(st_a[0], q2);
    chk(q1 == q2, "R4 rewrite same pair", 64'(q2), 64'(q1));

    // R9 read leaves memory unchanged
    do_read(st_a[1], q1);
    do_read(st_a[1], q2);
    chk(q1 == q2, "R9 repeat read", 64'(q2), 64'(q1));

    // R7 write and read offered together: write wins
    a = rand_code(ADDR_W); d = rand_code(DATA_W);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    rd_addr = a; rd_valid = 1'b1;
    #1;
    chk(wr_ready && !rd_ready, "R7 write priority", {wr_ready, rd_ready}, 2);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_write(a, d);
    #1;
    chk(!rd_ready && !wr_ready, "R7 busy after accept", {wr_ready, rd_ready}, 0);
    read_cmp(a, "R7 read sees write");

    // R2 rebuild after a second reset
    do_reset();
    a = rand_code(ADDR_W); d = rand_code(DATA_W);
    do_write(a, d);
    read_cmp(a, "R2 rows rebuilt");
    read_cmp(st_a[2], "R2 R3 other address");

    summary();
  end

endmodule